// File: doc/BRIEF.md
# Display Data Channel Chunk Reader

This block is a single-master I2C controller for the display data channel of a video transmitter. On a host command it fetches one 32-byte chunk of the sink's capability data into a local holding buffer. It writes the start offset to the capability device (7-bit address 50h, write), sends a repeated START, then reads 32 bytes from the same device (read direction). The host drains the buffer through a pop-style read port, then issues the next command with a new offset.

A second command mode performs a short read. It has no sub-address phase: START, the 7-bit address of the link-integrity port (3Ah by default) with the read bit, then a host-chosen number of bytes (1 to 32). This is used for periodic link-integrity polling of the content-protection receiver.

Both bus lines are open-drain: the block only pulls low or releases, and it waits while a slave holds SCL low. A slave that does not acknowledge aborts the transfer with a STOP and a NACK error. A line held low for longer than a programmable count is reported as a separate hang error. The bit timing is set by a quarter-period divider; the default of 250 system clocks per quarter gives 100 kHz from a 100 MHz clock.

Top module: `ddc_edid_fetch`

## Requirements
- R1: After reset, busy, done, err_nack and err_hang are 0, and scl_oe and sda_oe are 0 (both lines released). While busy is 0 both lines stay released.
- R2: A chunk command (cmd_go with cmd_short=0) writes address byte A0h, then the cmd_offset byte, then sends a repeated START and address byte A1h. It then reads 32 bytes, which the host pops in bus order, the first being the byte at cmd_offset.
- R3: During a read, every data byte except the last is acknowledged by the master (SDA low in the ninth bit), the last byte gets a NACK (SDA released), and a STOP follows.
- R4: A short command (cmd_go with cmd_short=1) sends START and the short-port address with the read bit (byte 75h by default), with no write phase. It then reads cmd_len_m1+1 bytes into the buffer, with the same ACK/NACK/STOP ending as R3.
- R5: busy rises in the cycle after cmd_go is accepted in idle and falls when the STOP completes (done pulses for one cycle). A cmd_go while busy is ignored.
- R6: A missing acknowledge after an address or offset byte sets err_nack, issues a STOP and ends the command with no data read.
- R7: While the master has released SCL but the line is still low (a slave stretching the clock), bit timing is held, and the transfer completes with correct data.
- R8: If SCL stays low while released, or SDA stays low while a START waits for it, for more than hang_limit cycles, the command ends at once with err_hang set and both lines released. No STOP is attempted.
- R9: The buffer read pointer and fill pointer return to zero when a command is accepted, so the first pop after any command returns that command's first byte.
- R10: The master changes its SDA drive while SCL is released only as part of a START or STOP condition.
- R11: err_nack and err_hang are cleared when the next command is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_go | input | 1 | Command strobe, accepted only when idle |
| cmd_short | input | 1 | 1 = short read without sub-address, 0 = 32-byte chunk fetch |
| cmd_offset | input | 8 | Start offset for a chunk fetch |
| cmd_len_m1 | input | 5 | Byte count minus one for a short read |
| hang_limit | input | 16 | Cycles a line may stay stuck low before the hang error |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle pulse when a command ends |
| err_nack | output | 1 | Slave failed to acknowledge an address or offset |
| err_hang | output | 1 | Bus line stuck low past the limit |
| rd_en | input | 1 | Pop one byte from the buffer |
| rd_data | output | 8 | Byte at the buffer read pointer |
| scl_in | input | 1 | Sensed SCL level |
| sda_in | input | 1 | Sensed SDA level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |

## Verification
On every cycle, the assertions check four things: lines are released when idle, SDA does not move under a high SCL except at START or STOP, the phase holds while SCL is stretched, and the buffer never overflows. They also check that busy rises only from a command, that a NACK leads straight to STOP, that a hang ends the command, and that the pointers clear when a command is accepted. The following can only be shown by the bench's scenarios, which use a behavioural open-drain slave: the exact bytes on the wire (offset, address and direction bytes), the ACK/NACK pattern across 32 bytes, the byte order seen by the host, the short-read framing, and recovery after a stretch, a NACK and a stuck bus.

// File: rtl/ddc_pkg.sv
package ddc_pkg;

    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_STOP  = 2'd1,
        OP_WR    = 2'd2,
        OP_RD    = 2'd3
    } bit_op_e;

    typedef struct packed {
        logic scl_rel;
        logic sda_rel;
    } line_t;

    typedef enum logic [2:0] {
        S_IDLE, S_START, S_WBIT, S_WACK, S_RBIT, S_MACK, S_STOP
    } xfer_st_e;

    typedef enum logic [1:0] {
        G_WADDR, G_OFFS, G_RADDR, G_DATA
    } stage_e;

    localparam logic [6:0] CAP_DEV_DEFAULT   = 7'h50;
    localparam logic [6:0] SHORT_DEV_DEFAULT = 7'h3A;

    // Line levels for each quarter of a bit-level operation.
    function automatic line_t phase_lines(bit_op_e op, logic [1:0] ph, logic wbit);
        line_t l;
        l = '{scl_rel: 1'b1, sda_rel: 1'b1};
        unique case (op)
            OP_START: begin
                l.scl_rel = (ph == 2'd1) || (ph == 2'd2);
                l.sda_rel = (ph == 2'd0) || (ph == 2'd1);
            end
            OP_STOP: begin
                l.scl_rel = (ph != 2'd0);
                l.sda_rel = (ph == 2'd3);
            end
            OP_WR: begin
                l.scl_rel = (ph == 2'd1) || (ph == 2'd2);
                l.sda_rel = wbit;
            end
            OP_RD: begin
                l.scl_rel = (ph == 2'd1) || (ph == 2'd2);
                l.sda_rel = 1'b1;
            end
        endcase
        return l;
    endfunction

endpackage

// File: rtl/ddc_bit_engine.sv
module ddc_bit_engine
    import ddc_pkg::*;
#(
    parameter int QDIV   = 250,
    parameter int HANG_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  bit_op_e           op,
    input  logic              wbit,
    input  logic [HANG_W-1:0] hang_limit,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              done,
    output logic              hang,
    output logic              rbit,
    output logic              scl_oe,
    output logic              sda_oe
);
    localparam int QW = (QDIV > 2) ? $clog2(QDIV) : 1;
    localparam logic [QW-1:0] QLAST = QW'(QDIV - 1);

    logic              run;
    logic [1:0]        ph;
    logic [QW-1:0]     qcnt;
    logic [HANG_W-1:0] hcnt;
    bit_op_e           op_q;
    logic              wbit_q;
    line_t             lines;
    logic [1:0]        scl_s, sda_s;
    logic              scl_hi, sda_hi, stall;

    assign scl_hi = scl_s[1];
    assign sda_hi = sda_s[1];
    assign stall  = run && ((lines.scl_rel && !scl_hi) ||
                            (op_q == OP_START && ph == 2'd1 && !sda_hi));
    assign scl_oe = !lines.scl_rel;
    assign sda_oe = !lines.sda_rel;

    always_ff @(posedge clk) begin
        if (rst) begin
            run    <= 1'b0;
            ph     <= 2'd0;
            qcnt   <= '0;
            hcnt   <= '0;
            op_q   <= OP_STOP;
            wbit_q <= 1'b1;
            lines  <= '{scl_rel: 1'b1, sda_rel: 1'b1};
            scl_s  <= 2'b11;
            sda_s  <= 2'b11;
            done   <= 1'b0;
            hang   <= 1'b0;
            rbit   <= 1'b1;
        end else begin
            scl_s <= {scl_s[0], scl_in};
            sda_s <= {sda_s[0], sda_in};
            done  <= 1'b0;
            hang  <= 1'b0;
            if (!run) begin
                if (go) begin
                    run    <= 1'b1;
                    op_q   <= op;
                    wbit_q <= wbit;
                    ph     <= 2'd0;
                    qcnt   <= '0;
                    hcnt   <= '0;
                    lines  <= phase_lines(op, 2'd0, wbit);
                end
            end else if (stall) begin
                if (hcnt >= hang_limit) begin
                    run   <= 1'b0;
                    hang  <= 1'b1;
                    lines <= '{scl_rel: 1'b1, sda_rel: 1'b1};
                end else begin
                    hcnt <= hcnt + 1'b1;
                end
            end else begin
                hcnt <= '0;
                if (qcnt == QLAST) begin
                    qcnt <= '0;
                    if (ph == 2'd2) rbit <= sda_hi;
                    if (ph == 2'd3) begin
                        run  <= 1'b0;
                        done <= 1'b1;
                    end else begin
                        ph    <= ph + 2'd1;
                        lines <= phase_lines(op_q, ph + 2'd1, wbit_q);
                    end
                end else begin
                    qcnt <= qcnt + 1'b1;
                end
            end
        end
    end

    // R10: SDA drive moves under released SCL only for START or STOP
    assert_sda_quiet_high_R10: assert property (@(posedge clk) disable iff (rst || hang)
        (lines.scl_rel && $past(lines.scl_rel) && (lines.sda_rel != $past(lines.sda_rel)))
        |-> (op_q == OP_START || op_q == OP_STOP));

    // R7: phase does not advance while a released SCL is still seen low
    assert_hold_on_stretch_R7: assert property (@(posedge clk) disable iff (rst)
        (run && lines.scl_rel && !scl_hi) |=> (ph == $past(ph)));

endmodule

// File: rtl/ddc_chunk_buf.sv
module ddc_chunk_buf #(
    parameter int DEPTH = 32,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data
);
    localparam int AW = $clog2(DEPTH);

    logic [DW-1:0] mem [DEPTH];
    logic [AW:0]   wptr;
    logic [AW-1:0] rptr;

    assign rd_data = mem[rptr];

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wptr <= '0;
            rptr <= '0;
        end else begin
            if (wr_en) begin
                mem[wptr[AW-1:0]] <= wr_data;
                wptr <= wptr + 1'b1;
            end
            if (rd_en) rptr <= rptr + 1'b1;
        end
    end

    // R2: a chunk never writes past the buffer depth
    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (wptr < (AW+1)'(DEPTH)));

    // R9: pointers return to zero when a command is accepted
    assert_ptr_clear_R9: assert property (@(posedge clk) disable iff (rst)
        clr |=> (rptr == '0 && wptr == '0));

endmodule

// File: rtl/ddc_edid_fetch.sv
module ddc_edid_fetch
    import ddc_pkg::*;
#(
    parameter int         QDIV      = 250,
    parameter int         HANG_W    = 16,
    parameter int         CHUNK     = 32,
    parameter logic [6:0] CAP_DEV   = CAP_DEV_DEFAULT,
    parameter logic [6:0] SHORT_DEV = SHORT_DEV_DEFAULT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_go,
    input  logic              cmd_short,
    input  logic [7:0]        cmd_offset,
    input  logic [4:0]        cmd_len_m1,
    input  logic [HANG_W-1:0] hang_limit,
    output logic              busy,
    output logic              done,
    output logic              err_nack,
    output logic              err_hang,
    input  logic              rd_en,
    output logic [7:0]        rd_data,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              scl_oe,
    output logic              sda_oe
);
    localparam int LW = $clog2(CHUNK);

    xfer_st_e    st;
    stage_e      stage;
    logic [7:0]  tx, rx, offs_q;
    logic [2:0]  bitn;
    logic [LW-1:0] remain;
    logic        issued;

    logic        accept;
    logic        eng_go, eng_wbit, eng_done, eng_hang, eng_rbit;
    bit_op_e     eng_op;
    logic        buf_wr;
    logic [7:0]  buf_wdata;

    assign accept    = (st == S_IDLE) && cmd_go;
    assign eng_go    = (st != S_IDLE) && !issued;
    assign buf_wr    = (st == S_RBIT) && eng_done && (bitn == 3'd7);
    assign buf_wdata = {rx[6:0], eng_rbit};

    always_comb begin
        eng_op   = OP_RD;
        eng_wbit = 1'b1;
        unique case (st)
            S_START: eng_op = OP_START;
            S_WBIT:  begin eng_op = OP_WR; eng_wbit = tx[7]; end
            S_MACK:  begin eng_op = OP_WR; eng_wbit = (remain == '0); end
            S_STOP:  eng_op = OP_STOP;
            default: eng_op = OP_RD;
        endcase
    end

    ddc_bit_engine #(.QDIV(QDIV), .HANG_W(HANG_W)) u_bit (
        .clk(clk), .rst(rst), .go(eng_go), .op(eng_op), .wbit(eng_wbit),
        .hang_limit(hang_limit), .scl_in(scl_in), .sda_in(sda_in),
        .done(eng_done), .hang(eng_hang), .rbit(eng_rbit),
        .scl_oe(scl_oe), .sda_oe(sda_oe)
    );

    ddc_chunk_buf #(.DEPTH(CHUNK), .DW(8)) u_buf (
        .clk(clk), .rst(rst), .clr(accept), .wr_en(buf_wr),
        .wr_data(buf_wdata), .rd_en(rd_en), .rd_data(rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= S_IDLE;
            stage    <= G_WADDR;
            tx       <= '0;
            rx       <= '0;
            offs_q   <= '0;
            bitn     <= '0;
            remain   <= '0;
            issued   <= 1'b0;
            busy     <= 1'b0;
            done     <= 1'b0;
            err_nack <= 1'b0;
            err_hang <= 1'b0;
        end else begin
            done <= 1'b0;
            if (eng_go) issued <= 1'b1;
            if (accept) begin
                busy     <= 1'b1;
                err_nack <= 1'b0;
                err_hang <= 1'b0;
                issued   <= 1'b0;
                bitn     <= '0;
                offs_q   <= cmd_offset;
                st       <= S_START;
                if (cmd_short) begin
                    tx     <= {SHORT_DEV, 1'b1};
                    stage  <= G_RADDR;
                    remain <= LW'(cmd_len_m1);
                end else begin
                    tx     <= {CAP_DEV, 1'b0};
                    stage  <= G_WADDR;
                    remain <= LW'(CHUNK - 1);
                end
            end else if (eng_hang) begin
                st       <= S_IDLE;
                busy     <= 1'b0;
                done     <= 1'b1;
                err_hang <= 1'b1;
                issued   <= 1'b0;
            end else if (eng_done) begin
                issued <= 1'b0;
                unique case (st)
                    S_START: begin
                        st   <= S_WBIT;
                        bitn <= '0;
                    end
                    S_WBIT: begin
                        tx   <= {tx[6:0], 1'b0};
                        bitn <= bitn + 3'd1;
                        if (bitn == 3'd7) st <= S_WACK;
                    end
                    S_WACK: begin
                        if (eng_rbit) begin
                            err_nack <= 1'b1;
                            st       <= S_STOP;
                        end else begin
                            unique case (stage)
                                G_WADDR: begin
                                    tx    <= offs_q;
                                    stage <= G_OFFS;
                                    st    <= S_WBIT;
                                    bitn  <= '0;
                                end
                                G_OFFS: begin
                                    tx    <= {CAP_DEV, 1'b1};
                                    stage <= G_RADDR;
                                    st    <= S_START;
                                end
                                default: begin
                                    stage <= G_DATA;
                                    st    <= S_RBIT;
                                    bitn  <= '0;
                                end
                            endcase
                        end
                    end
                    S_RBIT: begin
                        rx   <= {rx[6:0], eng_rbit};
                        bitn <= bitn + 3'd1;
                        if (bitn == 3'd7) st <= S_MACK;
                    end
                    S_MACK: begin
                        if (remain == '0) begin
                            st <= S_STOP;
                        end else begin
                            remain <= remain - 1'b1;
                            st     <= S_RBIT;
                        end
                    end
                    S_STOP: begin
                        st   <= S_IDLE;
                        busy <= 1'b0;
                        done <= 1'b1;
                    end
                    default: st <= S_IDLE;
                endcase
            end
        end
    end

    // R1: both lines released whenever no command is in progress
    assert_idle_released_R1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!scl_oe && !sda_oe));

    // R5: busy only rises from an accepted command strobe
    assert_busy_from_cmd_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(cmd_go));

    // R6: a missing acknowledge on an address/offset goes straight to STOP
    assert_nack_abort_R6: assert property (@(posedge clk) disable iff (rst)
        (st == S_WACK && eng_done && eng_rbit && !eng_hang) |=> (st == S_STOP && err_nack));

    // R8: a stuck line ends the command with the hang flag
    assert_hang_end_R8: assert property (@(posedge clk) disable iff (rst)
        (eng_hang && !accept) |=> (!busy && err_hang && done));

endmodule

// File: tb/tb_ddc_edid_fetch.sv
`timescale 1ns/1ps
module tb_ddc_edid_fetch;
    localparam int QDIV = 4;
    localparam logic [6:0] CAPD = 7'h50;
    localparam logic [6:0] SHD  = 7'h3A;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cmd_go = 1'b0, cmd_short = 1'b0;
    logic [7:0] cmd_offset = '0;
    logic [4:0] cmd_len_m1 = '0;
    logic [15:0] hang_limit = 16'd1000;
    logic busy, done, err_nack, err_hang, rd_en = 1'b0;
    logic [7:0] rd_data;
    logic scl_oe, sda_oe;
    logic s_scl_low = 1'b0, s_sda_low = 1'b0, stuck_scl = 1'b0;
    logic scl, sda;

    assign scl = !(scl_oe || s_scl_low || stuck_scl);
    assign sda = !(sda_oe || s_sda_low);

    always #2 clk = ~clk;

    ddc_edid_fetch #(.QDIV(QDIV), .HANG_W(16), .CHUNK(32)) dut (
        .clk(clk), .rst(rst), .cmd_go(cmd_go), .cmd_short(cmd_short),
        .cmd_offset(cmd_offset), .cmd_len_m1(cmd_len_m1), .hang_limit(hang_limit),
        .busy(busy), .done(done), .err_nack(err_nack), .err_hang(err_hang),
        .rd_en(rd_en), .rd_data(rd_data), .scl_in(scl), .sda_in(sda),
        .scl_oe(scl_oe), .sda_oe(sda_oe)
    );

    int checks = 0, errors = 0;

    function automatic logic [7:0] cap_byte(logic [7:0] a);
        return {a[3:0], a[7:4]} ^ 8'h96;
    endfunction
    function automatic logic [7:0] short_byte(logic [7:0] i);
        return 8'hB0 + i;
    endfunction

    // ---------------- behavioural open-drain slave ----------------
    localparam int M_IDLE = 0, M_ADDR = 1, M_AACK = 2, M_WR = 3, M_RD = 4, M_MACK = 5;
    int mode = M_IDLE, bitn = 0, stretch_cnt = 0, stretch_len = 0;
    int n_start = 0, n_stop = 0, n_wr = 0, n_sent = 0, n_nack = 0, n_short = 0;
    int n_stretch = 0, n_proto = 0;
    logic [7:0] sh = '0, cur = '0, ptr = '0, last_addr = '0, last_offs = '0;
    logic [6:0] dev = '0;
    logic rw = 1'b0, for_addr = 1'b0, mnack = 1'b0, ack_en = 1'b1, slv_kick = 1'b0;
    logic pscl = 1'b1, psda = 1'b1;

    always @(negedge clk) begin
        if (slv_kick) begin
            mode = M_IDLE; s_sda_low = 1'b0; s_scl_low = 1'b0; stretch_cnt = 0;
        end else begin
            if (stretch_cnt > 0) begin
                stretch_cnt = stretch_cnt - 1;
                if (stretch_cnt == 0) s_scl_low = 1'b0;
            end
            if (pscl && scl && psda && !sda) begin
                n_start++;
                if ((mode == M_ADDR || mode == M_WR) && bitn >= 2) n_proto++;
                mode = M_ADDR; bitn = 0; s_sda_low = 1'b0;
            end else if (pscl && scl && !psda && sda) begin
                n_stop++;
                if ((mode == M_ADDR || mode == M_WR) && bitn >= 2) n_proto++;
                mode = M_IDLE; s_sda_low = 1'b0;
            end else if (!pscl && scl) begin
                if (mode == M_ADDR || mode == M_WR) begin
                    sh = {sh[6:0], sda}; bitn++;
                end else if (mode == M_MACK) begin
                    mnack = sda;
                end
            end else if (pscl && !scl) begin
                case (mode)
                    M_ADDR: if (bitn == 8) begin
                        dev = sh[7:1]; rw = sh[0]; last_addr = sh;
                        for_addr = 1'b1;
                        if (ack_en && (dev == CAPD || dev == SHD)) begin
                            s_sda_low = 1'b1; mode = M_AACK;
                            if (dev == SHD) begin ptr = '0; n_short++; end
                            if (stretch_len > 0) begin
                                s_scl_low = 1'b1; stretch_cnt = stretch_len; n_stretch++;
                            end
                        end else mode = M_IDLE;
                    end
                    M_WR: if (bitn == 8) begin
                        n_wr++; last_offs = sh; ptr = sh;
                        s_sda_low = 1'b1; for_addr = 1'b0; mode = M_AACK;
                    end
                    M_AACK: begin
                        s_sda_low = 1'b0;
                        if (for_addr && rw) begin
                            cur = (dev == SHD) ? short_byte(ptr) : cap_byte(ptr);
                            s_sda_low = !cur[7]; bitn = 1; mode = M_RD;
                        end else begin
                            mode = M_WR; bitn = 0;
                        end
                    end
                    M_RD: if (bitn == 8) begin
                        s_sda_low = 1'b0; n_sent++; mode = M_MACK;
                    end else begin
                        s_sda_low = !cur[7-bitn]; bitn++;
                    end
                    M_MACK: if (mnack) begin
                        n_nack++; mode = M_IDLE;
                    end else begin
                        ptr = ptr + 8'd1;
                        cur = (dev == SHD) ? short_byte(ptr) : cap_byte(ptr);
                        s_sda_low = !cur[7]; bitn = 1; mode = M_RD;
                    end
                    default: ;
                endcase
            end
        end
        pscl = scl; psda = sda;
    end

    // ---------------- bench helpers ----------------
    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic issue(input logic sh_mode, input logic [7:0] off, input logic [4:0] lm1);
        @(negedge clk);
        cmd_go = 1'b1; cmd_short = sh_mode; cmd_offset = off; cmd_len_m1 = lm1;
        @(negedge clk);
        cmd_go = 1'b0;
    endtask

    task automatic wait_idle(input int limit, input string req);
        int n = 0;
        while (busy && n < limit) begin @(negedge clk); n++; end
        check(!busy, {req, " command did not end"}, busy, 0);
    endtask

    task automatic pop_check(input int n, input bit is_short, input logic [7:0] base,
                             input string req);
        int bad = 0, first_act = 0, first_exp = 0;
        for (int i = 0; i < n; i++) begin
            logic [7:0] e;
            @(negedge clk);
            e = is_short ? short_byte(8'(i)) : cap_byte(base + 8'(i));
            if (rd_data !== e) begin
                if (bad == 0) begin first_act = rd_data; first_exp = e; end
                bad++;
            end
            rd_en = 1'b1;
        end
        @(negedge clk);
        rd_en = 1'b0;
        check(bad == 0, {req, " buffer bytes"}, first_act, first_exp);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        check(busy == 1'b0, "R1 busy", busy, 0);
        check(scl_oe == 1'b0 && sda_oe == 1'b0, "R1 lines released", {scl_oe, sda_oe}, 0);
        check(err_nack == 1'b0 && err_hang == 1'b0, "R1 errors", {err_nack, err_hang}, 0);
        check(done == 1'b0, "R1 done", done, 0);
    endtask

    task automatic t_chunk();
        int s0 = n_start, p0 = n_stop, w0 = n_wr, d0 = n_sent, k0 = n_nack, h0 = n_short;
        issue(1'b0, 8'h10, 5'd0);
        check(busy == 1'b1, "R5 busy after accept", busy, 1);
        repeat (40) @(negedge clk);
        issue(1'b1, 8'h00, 5'd3);   // must be ignored (R5)
        wait_idle(20000, "R2");
        check(err_nack == 0 && err_hang == 0, "R2 no error", {err_nack, err_hang}, 0);
        check(n_start - s0 == 2, "R2 START plus repeated START", n_start - s0, 2);
        check(n_wr - w0 == 1 && last_offs == 8'h10, "R2 offset byte", last_offs, 8'h10);
        check(last_addr == 8'hA1, "R2 read address byte", last_addr, 8'hA1);
        check(n_sent - d0 == 32, "R3 bytes sent", n_sent - d0, 32);
        check(n_nack - k0 == 1, "R3 single NACK on last byte", n_nack - k0, 1);
        check(n_stop - p0 == 1, "R3 STOP", n_stop - p0, 1);
        check(n_short == h0, "R5 command while busy ignored", n_short - h0, 0);
        check(n_proto == 0, "R10 no stray START/STOP inside a byte", n_proto, 0);
        pop_check(32, 1'b0, 8'h10, "R2");
    endtask

    task automatic t_ptr_reset();
        issue(1'b0, 8'h40, 5'd0);
        wait_idle(20000, "R9");
        pop_check(5, 1'b0, 8'h40, "R9 partial drain");
        issue(1'b0, 8'h80, 5'd0);
        wait_idle(20000, "R9");
        pop_check(3, 1'b0, 8'h80, "R9 pointer restart");
    endtask

    task automatic t_short();
        int s0 = n_start, w0 = n_wr, d0 = n_sent, k0 = n_nack, h0 = n_short, p0 = n_stop;
        issue(1'b1, 8'hFF, 5'd2);
        wait_idle(20000, "R4");
        check(n_short - h0 == 1 && last_addr == 8'h75, "R4 short address byte", last_addr, 8'h75);
        check(n_wr == w0 && n_start - s0 == 1, "R4 no write phase", n_wr - w0, 0);
        check(n_sent - d0 == 3 && n_nack - k0 == 1 && n_stop - p0 == 1,
              "R4 three bytes then NACK and STOP", n_sent - d0, 3);
        pop_check(3, 1'b1, 8'h00, "R4");
    endtask

    task automatic t_nack();
        int d0 = n_sent, p0 = n_stop;
        ack_en = 1'b0;
        issue(1'b0, 8'h20, 5'd0);
        wait_idle(20000, "R6");
        check(err_nack == 1'b1, "R6 nack flag", err_nack, 1);
        check(n_stop - p0 == 1, "R6 STOP after NACK", n_stop - p0, 1);
        check(n_sent == d0, "R6 no data read", n_sent - d0, 0);
        check(scl_oe == 0 && sda_oe == 0, "R1 released after abort", {scl_oe, sda_oe}, 0);
        ack_en = 1'b1;
    endtask

    task automatic t_stretch();
        int t0 = n_stretch;
        stretch_len = 60;
        issue(1'b0, 8'h20, 5'd0);
        check(err_nack == 1'b0, "R11 nack cleared by new command", err_nack, 0);
        wait_idle(30000, "R7");
        stretch_len = 0;
        check(n_stretch - t0 == 2, "R7 stretches applied", n_stretch - t0, 2);
        check(err_hang == 0 && err_nack == 0, "R7 no error", {err_nack, err_hang}, 0);
        pop_check(32, 1'b0, 8'h20, "R7");
    endtask

    task automatic t_hang();
        hang_limit = 16'd100;
        issue(1'b0, 8'h00, 5'd0);
        repeat (150) @(negedge clk);
        stuck_scl = 1'b1;
        wait_idle(3000, "R8");
        check(err_hang == 1'b1, "R8 hang flag", err_hang, 1);
        check(err_nack == 1'b0, "R8 not a nack", err_nack, 0);
        check(scl_oe == 0 && sda_oe == 0, "R8 lines released", {scl_oe, sda_oe}, 0);
        stuck_scl = 1'b0;
        @(negedge clk); slv_kick = 1'b1;
        @(negedge clk); slv_kick = 1'b0;
        repeat (10) @(negedge clk);
        hang_limit = 16'd1000;
        issue(1'b1, 8'h00, 5'd1);
        check(err_hang == 1'b0, "R11 hang flag cleared by new command", err_hang, 0);
        wait_idle(20000, "R8 recovery");
        check(err_hang == 0 && err_nack == 0, "R8 recovery clean", {err_nack, err_hang}, 0);
        pop_check(2, 1'b1, 8'h00, "R8 recovery");
    endtask

    bit finished = 1'b0;

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        t_reset();
        t_chunk();
        t_ptr_reset();
        t_short();
        t_nack();
        t_stretch();
        t_hang();
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule